// File: doc/BRIEF.md
# Half-Precision to Single-Precision Widener

This block takes a 16-bit IEEE 754 binary16 value and produces the binary32 value that has the same numeric meaning. There is one register stage between input and output. A word is accepted on any cycle where `in_valid` is high, and its converted form appears on `data_out` one cycle later, with `out_valid` high. Every binary16 value can be represented exactly in binary32, so no rounding takes place and no exception flags are produced.

The conversion handles every input class:

- **Signed zero**: passes through with only the sign bit moved.
- **Normal numbers**: the exponent is rebiased and the fraction is widened.
- **Subnormals**: become binary32 normals. A leading-one detector supplies the normalising shift in a single cycle.
- **Infinities**: keep their sign.
- **NaNs**: keep their 10-bit payload in the upper fraction bits, and all widened lower fraction bits are set to one.

Top module: `h2s_widen`

## Requirements
- R1: Output bit 31 equals input bit 15 for every input class.
- R2: For an input exponent field (bits 14:10) in the range 1..30, the output exponent field (bits 30:23) is the input exponent plus 112. Output bits 22:13 equal input bits 9:0, and output bits 12:0 are zero.
- R3: An input with bits 14:0 all zero gives output bits 30:0 all zero.
- R4: An input with exponent field zero and nonzero fraction is converted as follows:
  - Let p be the index of the highest set fraction bit and s = 10 - p, so s lies in 1..10.
  - The output exponent field is 113 - s, which lies in 103..112.
  - Output bits 22:13 are the fraction shifted left by s, keeping the low 10 bits.
  - Output bits 12:0 are zero.
- R5: An input with exponent field 31 and zero fraction gives output exponent 0xFF and output fraction zero.
- R6: An input with exponent field 31 and nonzero fraction gives output exponent 0xFF. Output bits 22:13 equal input bits 9:0, and output bits 12:0 are all ones.
- R7: `out_valid` equals the value `in_valid` had one cycle earlier. Results leave in the same order the inputs arrived, one result per accepted input.
- R8: While `rst` is high at a rising clock edge, `out_valid` and `data_out` become zero.
- R9: In a cycle where `in_valid` is low, `data_out` keeps its previous value, whatever is driven on `data_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `data_in` as a word to convert |
| data_in | input | 16 | binary16 operand |
| out_valid | output | 1 | Marks `data_out` as a fresh result |
| data_out | output | 32 | binary32 result, registered |

## Verification
The clocked properties assume that `in_valid` and `data_in` carry known values at every rising edge once reset is released. They also assume that reset is held for at least one edge before any checked behaviour begins. The stimulus meets these assumptions:

- It drives inputs only at falling edges and keeps every input at a defined value from time zero.
- It asserts reset for several edges before sending the first word.
- It presents each of the 65536 binary16 codes once, in ascending order, so that every sign, class and subnormal shift amount is covered.
- At regular intervals it inserts idle cycles with arbitrary data on `data_in`, which tests that the output holds its value while `in_valid` is low.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

  // Class of a floating-point operand, decided from its exponent and fraction fields.
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fp_class_e;

endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output fp_class_e         cls_o
);

  logic exp_zero;
  logic exp_ones;
  logic frac_nz;

  assign exp_zero = ~|exp_i;
  assign exp_ones = &exp_i;
  assign frac_nz  = |frac_i;

  always_comb begin
    if (exp_zero) begin
      cls_o = frac_nz ? CLS_SUB : CLS_ZERO;
    end else if (exp_ones) begin
      cls_o = frac_nz ? CLS_NAN : CLS_INF;
    end else begin
      cls_o = CLS_NORM;
    end
  end

endmodule

// File: rtl/h2s_lod.sv
module h2s_lod #(
  parameter int W  = 10,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          found_o
);

  // One-hot marker of the highest set bit.
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_hit
    if (i == W - 1) begin : g_top
      assign hit[i] = vec_i[i];
    end else begin : g_low
      assign hit[i] = vec_i[i] & ~(|vec_i[W-1:i+1]);
    end
  end

  // Turn the one-hot marker into a binary index.
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) begin
        pos_o = pos_o | PW'(i);
      end
    end
  end

  assign found_o = |vec_i;

endmodule

// File: rtl/h2s_core.sv
module h2s_core
  import h2s_pkg::*;
#(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 8,
  parameter int OUT_FRAC_W = 23
) (
  input  logic [IN_EXP_W+IN_FRAC_W:0]   half_i,
  output logic [OUT_EXP_W+OUT_FRAC_W:0] single_o
);

  localparam int IN_W      = 1 + IN_EXP_W + IN_FRAC_W;
  localparam int PAD       = OUT_FRAC_W - IN_FRAC_W;
  localparam int IN_BIAS   = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS  = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF = OUT_BIAS - IN_BIAS;
  localparam int PW        = $clog2(IN_FRAC_W);
  localparam int SW        = $clog2(IN_FRAC_W + 1);

  logic                  sgn;
  logic [IN_EXP_W-1:0]   h_exp;
  logic [IN_FRAC_W-1:0]  h_frac;
  fp_class_e             cls;

  assign sgn    = half_i[IN_W-1];
  assign h_exp  = half_i[IN_W-2 -: IN_EXP_W];
  assign h_frac = half_i[IN_FRAC_W-1:0];

  h2s_classify #(
    .EXP_W  (IN_EXP_W),
    .FRAC_W (IN_FRAC_W)
  ) u_cls (
    .exp_i  (h_exp),
    .frac_i (h_frac),
    .cls_o  (cls)
  );

  logic [PW-1:0] lead_pos;
  logic          lead_found;

  h2s_lod #(
    .W  (IN_FRAC_W),
    .PW (PW)
  ) u_lod (
    .vec_i   (h_frac),
    .pos_o   (lead_pos),
    .found_o (lead_found)
  );

  // Subnormal normalisation: shift by (width - leading index), then drop the hidden bit.
  logic [SW-1:0]        sub_shift;
  logic [IN_FRAC_W-1:0] sub_frac;
  logic [OUT_EXP_W-1:0] sub_exp;

  assign sub_shift = SW'(IN_FRAC_W) - SW'(lead_pos);
  assign sub_frac  = h_frac << sub_shift;
  assign sub_exp   = OUT_EXP_W'(BIAS_DIFF + 1) - OUT_EXP_W'(sub_shift);

  logic [OUT_EXP_W-1:0]  o_exp;
  logic [OUT_FRAC_W-1:0] o_frac;

  always_comb begin
    o_exp  = '0;
    o_frac = '0;
    unique case (cls)
      CLS_ZERO: begin
        o_exp  = '0;
        o_frac = '0;
      end
      CLS_SUB: begin
        if (lead_found) begin
          o_exp  = sub_exp;
          o_frac = {sub_frac, {PAD{1'b0}}};
        end
      end
      CLS_NORM: begin
        o_exp  = OUT_EXP_W'(h_exp) + OUT_EXP_W'(BIAS_DIFF);
        o_frac = {h_frac, {PAD{1'b0}}};
      end
      CLS_INF: begin
        o_exp  = '1;
        o_frac = '0;
      end
      CLS_NAN: begin
        o_exp  = '1;
        o_frac = {h_frac, {PAD{1'b1}}};
      end
      default: begin
        o_exp  = '0;
        o_frac = '0;
      end
    endcase
  end

  assign single_o = {sgn, o_exp, o_frac};

endmodule

// File: rtl/h2s_widen.sv
module h2s_widen #(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 8,
  parameter int OUT_FRAC_W = 23
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [IN_EXP_W+IN_FRAC_W:0]           data_in,
  output logic                                  out_valid,
  output logic [OUT_EXP_W+OUT_FRAC_W:0]         data_out
);

  localparam int IN_W  = 1 + IN_EXP_W + IN_FRAC_W;
  localparam int OUT_W = 1 + OUT_EXP_W + OUT_FRAC_W;
  localparam int PAD   = OUT_FRAC_W - IN_FRAC_W;
  localparam int BIAS_DIFF = ((1 << (OUT_EXP_W - 1)) - 1) - ((1 << (IN_EXP_W - 1)) - 1);

  logic [OUT_W-1:0] conv;

  h2s_core #(
    .IN_EXP_W   (IN_EXP_W),
    .IN_FRAC_W  (IN_FRAC_W),
    .OUT_EXP_W  (OUT_EXP_W),
    .OUT_FRAC_W (OUT_FRAC_W)
  ) u_core (
    .half_i   (data_in),
    .single_o (conv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      data_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        data_out <= conv;
      end
    end
  end

  // Field views used by the properties below.
  logic [IN_EXP_W-1:0]   in_exp;
  logic [IN_FRAC_W-1:0]  in_frac;
  logic [OUT_EXP_W-1:0]  out_exp;
  logic [OUT_FRAC_W-1:0] out_frac;

  assign in_exp   = data_in[IN_W-2 -: IN_EXP_W];
  assign in_frac  = data_in[IN_FRAC_W-1:0];
  assign out_exp  = data_out[OUT_W-2 -: OUT_EXP_W];
  assign out_frac = data_out[OUT_FRAC_W-1:0];

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(data_out));

  assert_sign_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> data_out[OUT_W-1] == $past(data_in[IN_W-1]));

  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_exp == '0 && in_frac == '0) |=> data_out[OUT_W-2:0] == '0);

  assert_normal_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_exp != '0 && !(&in_exp)) |=>
      (out_exp == OUT_EXP_W'($past(in_exp)) + OUT_EXP_W'(BIAS_DIFF)) &&
      (out_frac[OUT_FRAC_W-1:PAD] == $past(in_frac)) && (out_frac[PAD-1:0] == '0));

  assert_subn_range_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_exp == '0 && in_frac != '0) |=>
      (out_exp >= OUT_EXP_W'(BIAS_DIFF + 1 - IN_FRAC_W)) &&
      (out_exp <= OUT_EXP_W'(BIAS_DIFF)) && (out_frac[PAD-1:0] == '0));

  assert_inf_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&in_exp) && in_frac == '0) |=> (&out_exp) && out_frac == '0);

  assert_nan_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&in_exp) && in_frac != '0) |=>
      (&out_exp) && (&out_frac[PAD-1:0]) &&
      (out_frac[OUT_FRAC_W-1:PAD] == $past(in_frac)));

endmodule

// File: tb/sim_h2s_widen.sv
module sim_h2s_widen;

  typedef struct packed {
    logic [15:0] din;
    logic [31:0] want;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] data_in = '0;
  logic        out_valid;
  logic [31:0] data_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] last_out = '0;
  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  h2s_widen u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .data_in   (data_in),
    .out_valid (out_valid),
    .data_out  (data_out)
  );

  // Reference conversion, normalising subnormals one bit at a time.
  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  f;
    logic [10:0] m;
    int          ex;
    s = h[15];
    e = h[14:10];
    f = h[9:0];
    if (e == 5'd0 && f == 10'd0) return {s, 31'd0};
    if (e == 5'd31) begin
      if (f == 10'd0) return {s, 8'hFF, 23'd0};
      return {s, 8'hFF, f, 13'h1FFF};
    end
    if (e == 5'd0) begin
      m = {1'b0, f};
      ex = 113;
      while (!m[10]) begin
        m = m << 1;
        ex = ex - 1;
      end
      return {s, 8'(ex), m[9:0], 13'd0};
    end
    return {s, 8'(int'(e) + 112), f, 13'd0};
  endfunction

  function automatic string req_tag(input logic [15:0] h);
    if (h[14:10] == 5'd0) return (h[9:0] == 10'd0) ? "R3 R1" : "R4 R1";
    if (h[14:10] == 5'd31) return (h[9:0] == 10'd0) ? "R5 R1" : "R6 R1";
    return "R2 R1";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%08h expected=%08h", req, got, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Scoreboard monitor: samples one time unit after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (out_valid) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R7 unexpected result", data_out, 32'd0);
          end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(data_out === it.want, req_tag(it.din), data_out, it.want);
          end
          last_out = data_out;
        end else begin
          check(data_out === last_out, "R9 hold", data_out, last_out);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        failures++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        finish_run();
      end
    end
  end

  // Driver.
  initial begin
    rst = 1'b1;
    in_valid = 1'b1;
    data_in = 16'h3C00;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R8 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check(data_out === 32'd0, "R8 data_out in reset", data_out, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      in_valid = 1'b1;
      data_in = 16'(v);
      sb_q.push_back('{din: 16'(v), want: ref_widen(16'(v))});
      if ((v % 4096) == 4095) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          in_valid = 1'b0;
          data_in = 16'(v * 7 + k * 13 + 1);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R7 results outstanding", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end

endmodule